// File: doc/BRIEF.md
# Multi-Queue Transmit Priority Scheduler

This block picks the next transmit descriptor to send. It watches up to sixteen ring queues and steers each grant into one of up to seven prioritized DMA FIFO channels. A programmable table binds every queue to exactly one channel, and any channel may collect several queues. In each cycle the block considers only the channels whose downstream side reports ready. It picks the most important of those channels that has work, then picks one eligible queue of that channel in rotating order.

A queue is eligible when it is marked active, holds at least one descriptor, and is not blocked by its transmit mode. A queue in windowed (block-ack) mode may be granted on back-to-back cycles. A queue in strict in-order mode may have only one descriptor outstanding, until a completion pulse for that queue arrives. The command queue always stays in in-order mode. Channels 0 to 3 carry background, best-effort, video and voice/management traffic, in that rising order of importance. Queues above the first seven map onto those four channels for aggregated traffic.

The grant is registered. A decision taken from the inputs seen at a clock edge appears on the grant outputs just after that edge.

Top module: `txq_prio_sched`

## Requirements
- R1: After reset no grant is shown, every queue is in in-order mode, queue q with q < NUM_CH is bound to channel q, and queue q with q >= NUM_CH is bound to channel q mod AGG_CH.
- R2: A grant names a queue that was active, non-empty and not blocked in the deciding cycle, and whose bound channel had ch_ready set. With no such queue, gnt_valid is low in the following cycle.
- R3: Among the ready channels that have an eligible queue, the channel with the highest index wins.
- R4: Within one channel, the search starts at the queue index just above that channel's last granted queue and wraps from NUM_Q-1 to 0. After reset each channel starts its search at queue 0.
- R5: A table write (cfg_we with cfg_queue, cfg_chan, cfg_inorder) changes the binding from the next decision on. The decision taken in the same cycle as the write uses the old binding.
- R6: A write whose cfg_chan is NUM_CH or above is ignored in full, for both the binding and the mode.
- R7: cfg_inorder=1 selects in-order mode and cfg_inorder=0 selects windowed mode. An in-order queue is not granted again after a grant until a q_done pulse for it has been seen. A windowed queue may be granted in consecutive cycles.
- R8: A write to queue CMD_Q updates its channel but keeps it in in-order mode, whatever cfg_inorder says.
- R9: At most one grant is shown per cycle, carrying both queue index and channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_active | input | NUM_Q | Per-queue participation enable |
| q_nonempty | input | NUM_Q | Per-queue descriptor-present flag |
| q_done | input | NUM_Q | Per-queue completion pulse that releases an in-order queue |
| ch_ready | input | NUM_CH | Per-channel downstream ready |
| cfg_we | input | 1 | Table write strobe |
| cfg_queue | input | log2(NUM_Q) | Queue being configured |
| cfg_chan | input | log2(NUM_CH) | Channel to bind the queue to |
| cfg_inorder | input | 1 | 1 = in-order mode, 0 = windowed mode |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_queue | output | log2(NUM_Q) | Granted queue index |
| gnt_chan | output | log2(NUM_CH) | Channel the grant is steered into |

## Verification
A corrupted binding entry shows up on the very next grant for that queue, as the wrong gnt_chan or as a missing grant when only the intended channel is ready. A rotation pointer that is off shows up as a wrong gnt_queue within one pass around the queues that share a channel. An in-order blocking flag that sticks starves its queue forever, and one that never sets gives a second grant one cycle later. The bench therefore drives each case for a few consecutive cycles and compares every cycle's grant.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

    // Transmit mode per queue (R7)
    typedef enum logic {
        MODE_WINDOW  = 1'b0,
        MODE_INORDER = 1'b1
    } qmode_e;

    // Binding loaded at reset: low queues one-to-one, the rest folded onto
    // the aggregation channels (R1)
    function automatic int reset_chan(int q, int n_ch, int n_agg);
        return (q < n_ch) ? q : (q % n_agg);
    endfunction

    // Wrapping search position
    function automatic int wrap_idx(int base, int step, int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/txq_map_table.sv
module txq_map_table
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 7,
    parameter int AGG_CH = 4,
    parameter int CMD_Q  = 4,
    localparam int QW = $clog2(NUM_Q),
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [QW-1:0] wr_queue,
    input  logic [CW-1:0] wr_chan,
    input  logic          wr_inorder,
    output logic [CW-1:0] chan_of [NUM_Q],
    output qmode_e        mode_of [NUM_Q]
);

    logic wr_ok;
    assign wr_ok = wr_en && (int'(wr_chan) < NUM_CH) && (int'(wr_queue) < NUM_Q);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NUM_Q; q++) begin
                chan_of[q] <= CW'(reset_chan(q, NUM_CH, AGG_CH));
                mode_of[q] <= MODE_INORDER;
            end
        end else if (wr_ok) begin
            chan_of[wr_queue] <= wr_chan;
            if (int'(wr_queue) == CMD_Q)
                mode_of[wr_queue] <= MODE_INORDER;
            else
                mode_of[wr_queue] <= qmode_e'(wr_inorder);
        end
    end

    // R5
    map_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_chan) < NUM_CH) && (int'(wr_queue) < NUM_Q))
        |=> (chan_of[$past(wr_queue)] == $past(wr_chan)));

endmodule

// File: rtl/txq_inflight.sv
module txq_inflight
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [QW-1:0]    fire_q,
    input  qmode_e           mode_of [NUM_Q],
    input  logic [NUM_Q-1:0] done,
    output logic [NUM_Q-1:0] busy
);

    logic [NUM_Q-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (fire && mode_of[fire_q] == MODE_INORDER)
            set_vec[fire_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= (busy & ~done) | set_vec;
    end

    // R7
    no_regrant_busy_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> !busy[fire_q]);

endmodule

// File: rtl/txq_rr_pick.sv
module txq_rr_pick
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] req,
    input  logic [QW-1:0]    last,
    output logic             any,
    output logic [QW-1:0]    pick
);

    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= NUM_Q; k++) begin
            if (!any && req[wrap_idx(int'(last), k, NUM_Q)]) begin
                any  = 1'b1;
                pick = QW'(wrap_idx(int'(last), k, NUM_Q));
            end
        end
    end

endmodule

// File: rtl/txq_prio_sched.sv
module txq_prio_sched
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 7,
    parameter int AGG_CH = 4,
    parameter int CMD_Q  = 4,
    localparam int QW = $clog2(NUM_Q),
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_Q-1:0]  q_active,
    input  logic [NUM_Q-1:0]  q_nonempty,
    input  logic [NUM_Q-1:0]  q_done,
    input  logic [NUM_CH-1:0] ch_ready,
    input  logic              cfg_we,
    input  logic [QW-1:0]     cfg_queue,
    input  logic [CW-1:0]     cfg_chan,
    input  logic              cfg_inorder,
    output logic              gnt_valid,
    output logic [QW-1:0]     gnt_queue,
    output logic [CW-1:0]     gnt_chan
);

    typedef struct packed {
        logic          valid;
        logic [QW-1:0] queue;
        logic [CW-1:0] chan;
    } grant_t;

    logic [CW-1:0]     chan_of [NUM_Q];
    qmode_e            mode_of [NUM_Q];
    logic [NUM_Q-1:0]  busy;
    logic [NUM_Q-1:0]  elig;
    logic [NUM_CH-1:0] ch_any;
    logic [QW-1:0]     ch_pick [NUM_CH];
    logic [QW-1:0]     last_q  [NUM_CH];
    grant_t            win;
    grant_t            gnt_r;

    txq_map_table #(
        .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .AGG_CH(AGG_CH), .CMD_Q(CMD_Q)
    ) u_map (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_queue(cfg_queue), .wr_chan(cfg_chan),
        .wr_inorder(cfg_inorder),
        .chan_of(chan_of), .mode_of(mode_of)
    );

    txq_inflight #(.NUM_Q(NUM_Q)) u_inflight (
        .clk(clk), .rst(rst),
        .fire(win.valid), .fire_q(win.queue),
        .mode_of(mode_of), .done(q_done), .busy(busy)
    );

    assign elig = q_active & q_nonempty & ~busy;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [NUM_Q-1:0] req;
        always_comb begin
            for (int q = 0; q < NUM_Q; q++)
                req[q] = elig[q] && (chan_of[q] == CW'(c));
        end
        txq_rr_pick #(.NUM_Q(NUM_Q)) u_pick (
            .req(req), .last(last_q[c]), .any(ch_any[c]), .pick(ch_pick[c])
        );
    end

    // strict priority: highest ready channel index with work wins
    always_comb begin
        win = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_any[c] && ch_ready[c]) begin
                win.valid = 1'b1;
                win.chan  = CW'(c);
            end
        end
        win.queue = ch_pick[win.chan];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_r <= '0;
            for (int c = 0; c < NUM_CH; c++)
                last_q[c] <= QW'(NUM_Q - 1);
        end else begin
            gnt_r <= win;
            if (win.valid)
                last_q[win.chan] <= win.queue;
        end
    end

    assign gnt_valid = gnt_r.valid;
    assign gnt_queue = gnt_r.queue;
    assign gnt_chan  = gnt_r.chan;

    // R2
    win_ready_chk: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> ch_ready[win.chan]);

    // R2
    win_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (q_active[win.queue] && q_nonempty[win.queue]
                       && chan_of[win.queue] == win.chan));

    // R3
    win_top_prio_chk: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (((ch_any & ch_ready) >> win.chan) == NUM_CH'(1)));

    // R2
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        ((ch_any & ch_ready) == '0) |=> !gnt_valid);

endmodule

// File: tb/tb_txq_prio_sched.sv
`timescale 1ns/1ps
module tb_txq_prio_sched;

    localparam int NQ = 16;
    localparam int NC = 7;
    localparam int NA = 4;
    localparam int CQ = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NQ-1:0] q_active = '0;
    logic [NQ-1:0] q_nonempty = '0;
    logic [NQ-1:0] q_done = '0;
    logic [NC-1:0] ch_ready = '0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_queue = '0;
    logic [2:0]    cfg_chan = '0;
    logic          cfg_inorder = 1'b0;
    logic          gnt_valid;
    logic [3:0]    gnt_queue;
    logic [2:0]    gnt_chan;

    always #5 clk = ~clk;

    txq_prio_sched #(.NUM_Q(NQ), .NUM_CH(NC), .AGG_CH(NA), .CMD_Q(CQ)) dut (
        .clk(clk), .rst(rst),
        .q_active(q_active), .q_nonempty(q_nonempty), .q_done(q_done),
        .ch_ready(ch_ready),
        .cfg_we(cfg_we), .cfg_queue(cfg_queue), .cfg_chan(cfg_chan),
        .cfg_inorder(cfg_inorder),
        .gnt_valid(gnt_valid), .gnt_queue(gnt_queue), .gnt_chan(gnt_chan)
    );

    typedef struct {
        bit    v;
        int    q;
        int    c;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done_run = 0;

    // reference state, kept from the requirements
    int m_chan [NQ];
    bit m_fifo [NQ];
    bit m_busy [NQ];
    int m_last [NC];

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            m_chan[q] = (q < NC) ? q : q % NA;   // R1
            m_fifo[q] = 1'b1;
            m_busy[q] = 1'b0;
        end
        for (int c = 0; c < NC; c++) m_last[c] = NQ - 1;
    endtask

    // driver: one decision cycle, pushes the expected grant
    task automatic cyc(input logic [NQ-1:0] act, input logic [NQ-1:0] ne,
                       input logic [NQ-1:0] dn, input logic [NC-1:0] rdy,
                       input bit we, input int wq, input int wc, input bit wm,
                       input string tag);
        exp_t e;
        @(negedge clk);
        q_active = act; q_nonempty = ne; q_done = dn; ch_ready = rdy;
        cfg_we = we; cfg_queue = 4'(wq); cfg_chan = 3'(wc); cfg_inorder = wm;
        e.v = 0; e.q = 0; e.c = 0; e.tag = tag;
        for (int c = NC - 1; c >= 0; c--) begin
            if (!e.v && rdy[c]) begin
                for (int k = 1; k <= NQ; k++) begin
                    int q;
                    q = (m_last[c] + k) % NQ;
                    if (!e.v && act[q] && ne[q] && !m_busy[q] && m_chan[q] == c) begin
                        e.v = 1; e.q = q; e.c = c;
                    end
                end
            end
        end
        for (int q = 0; q < NQ; q++) if (dn[q]) m_busy[q] = 1'b0;
        if (e.v) begin
            m_last[e.c] = e.q;
            if (m_fifo[e.q]) m_busy[e.q] = 1'b1;
        end
        if (we && wc < NC) begin
            m_chan[wq] = wc;
            m_fifo[wq] = (wq == CQ) ? 1'b1 : wm;
        end
        exp_q.push_back(e);
    endtask

    task automatic idle(input logic [NQ-1:0] dn, input string tag);
        cyc('0, '0, dn, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int q, input int c, input bit m, input string tag);
        cyc('0, '0, '0, '0, 1, q, c, m, tag);
    endtask

    // monitor: compares each grant with the expected item
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (gnt_valid !== e.v || (e.v && (int'(gnt_queue) != e.q || int'(gnt_chan) != e.c))) begin
                    n_fail++;
                    $display("FAIL %s: actual v=%0b q=%0d ch=%0d expected v=%0b q=%0d ch=%0d",
                             e.tag, gnt_valid, gnt_queue, gnt_chan, e.v, e.q, e.c);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done_run) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog (all reqs): actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    localparam logic [NC-1:0] ALL_CH = '1;
    localparam logic [NQ-1:0] ALL_Q  = '1;

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: no grant while in reset
        n_chk++;
        if (gnt_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual v=%0b expected v=0", gnt_valid);
        end
        rst = 1'b0;

        // R1: idle after reset, then default fold of queue 9 onto channel 1
        idle('0, "R1 idle");
        cyc(16'h0200, 16'h0200, '0, 7'b0000010, 0, 0, 0, 0, "R1 default map q9");
        idle(16'h0200, "R1 release");

        // R2: gating by active, non-empty and ready
        cyc(16'h0004, 16'h0000, '0, ALL_CH, 0, 0, 0, 0, "R2 empty");
        cyc(16'h0000, 16'h0004, '0, ALL_CH, 0, 0, 0, 0, "R2 inactive");
        cyc(16'h0004, 16'h0004, '0, ~7'b0000100, 0, 0, 0, 0, "R2 not ready");
        cyc(16'h0004, 16'h0004, '0, ALL_CH, 0, 0, 0, 0, "R2 grant");
        idle(16'h0004, "R2 release");

        // R3: strict priority across channels
        for (int i = 0; i < 4; i++)
            cyc(16'h002A, 16'h002A, '0, ALL_CH, 0, 0, 0, 0, "R3 priority");
        idle(ALL_Q, "R3 release");

        // R4: rotation inside channel 3 among windowed queues 3, 7, 11
        wr(3, 3, 0, "R4 cfg");
        wr(7, 3, 0, "R4 cfg");
        wr(11, 3, 0, "R4 cfg");
        for (int i = 0; i < 5; i++)
            cyc(16'h0888, 16'h0888, '0, 7'b0001000, 0, 0, 0, 0, "R4 rotate");
        // R7: windowed queue granted back to back
        for (int i = 0; i < 2; i++)
            cyc(16'h0080, 16'h0080, '0, 7'b0001000, 0, 0, 0, 0, "R7 windowed repeat");

        // R5: write in the deciding cycle uses the old binding
        cyc(16'h0080, 16'h0080, '0, 7'b0001001, 1, 7, 0, 0, "R5 same cycle old map");
        cyc(16'h0080, 16'h0080, '0, 7'b0001001, 0, 0, 0, 0, "R5 next cycle new map");

        // R6: write to a nonexistent channel is dropped
        cyc('0, '0, '0, '0, 1, 7, 7, 1, "R6 bad write");
        cyc(16'h0080, 16'h0080, '0, 7'b0000001, 0, 0, 0, 0, "R6 binding kept");
        cyc(16'h0080, 16'h0080, '0, 7'b0000001, 0, 0, 0, 0, "R6 mode kept");

        // R7: in-order queue 6 waits for its completion pulse
        for (int i = 0; i < 3; i++)
            cyc(16'h0040, 16'h0040, '0, ALL_CH, 0, 0, 0, 0, "R7 inorder hold");
        cyc(16'h0040, 16'h0040, 16'h0040, ALL_CH, 0, 0, 0, 0, "R7 done cycle");
        cyc(16'h0040, 16'h0040, '0, ALL_CH, 0, 0, 0, 0, "R7 regrant");

        // R8: command queue stays in-order even when asked for windowed
        wr(CQ, 2, 0, "R8 cfg");
        for (int i = 0; i < 3; i++)
            cyc(16'h0010, 16'h0010, '0, ALL_CH, 0, 0, 0, 0, "R8 cmd inorder");
        idle(ALL_Q, "R8 release");

        // R9: full load, one grant per cycle
        for (int i = 0; i < 6; i++)
            cyc(ALL_Q, ALL_Q, ALL_Q, ALL_CH, 0, 0, 0, 0, "R9 full load");

        idle('0, "tail");
        repeat (3) @(negedge clk);
        done_run = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule